// File: doc/BRIEF.md
# Extended Interrupt Priority Bank with Security Filtering

This block stores an 8-bit urgency value for each interrupt in a block of extended per-processor interrupts. Four values share one 32-bit word, and a memory-mapped port reads and writes those words. Software reaches the words through a fixed window of offsets in its frame, and byte strobes let it change single values. A lower stored value means a more urgent interrupt. The same stored values also drive a combinational lookup port, which a downstream arbiter uses to get the urgency of any interrupt ID.

Every byte field is filtered on each access. The filter depends on the interrupt's group, a global security-disable input, the security attribute of the access, and whether the interrupt is implemented at all. A blocked field reads as zero and keeps its contents when written. A write takes effect at one clock edge, so the lookup port shows either the old value or the new one and never anything in between.

Top module: `xppi_prio_bank`

## Requirements
- R1: After synchronous reset every stored priority is 0x00, `rsp_rdata` is zero, and the lookup port returns zero for every ID.
- R2: Word n (n = 8..23) is decoded at byte offset 0x400 + 4*n, and address bits [1:0] are ignored. A read of any other offset returns zero. A write to any other offset changes no stored value.
- R3: Interrupt ID m lives in word n = (m - 1024) div 4, in lane m mod 4. Lane k occupies bits [8k+7:8k]. With the default parameters, IDs 1056 to 1119 map onto words 8 to 23.
- R4: A write updates only those lanes whose `req_strb` bit is set. A lane with a clear strobe bit keeps its value.
- R5: `irq_group` holds two bits per interrupt, with bits [2i+1:2i] for ID 1056+i. The codes are 00 for Group 0, 01 for Secure Group 1 and 10 for Non-secure Group 1, and 11 is handled as a secure group. While `sec_disable` is 0, a non-secure access to a field whose code is not 10 reads zero, and a write to that field is dropped.
- R6: Secure accesses, all accesses while `sec_disable` is 1, and non-secure accesses to Non-secure Group 1 fields can read and write every implemented field.
- R7: Fields of IDs at or above 1056 + NUM_IMPL (default 56, so IDs 1112..1119) are not implemented. For any access security they read zero, ignore writes, and return zero on the lookup port.
- R8: Read data appears on `rsp_rdata` in the cycle after the read request. In every cycle that does not follow a read request, `rsp_rdata` is zero.
- R9: `lookup_prio` returns the stored priority of `lookup_id` combinationally. It returns zero for IDs outside the implemented range. A written value is visible on the lookup port right after the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_disable | input | 1 | Global security-disable control; 1 lifts the group filter |
| irq_group | input | 8*NUM_REGS | Two-bit group code per interrupt |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure access |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_strb | input | 4 | Byte-lane write strobes |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| lookup_id | input | ID_W | Interrupt ID to look up |
| lookup_prio | output | 8 | Priority of `lookup_id` |

## Verification
The bench runs secure, non-secure and security-disabled accesses across all four group codes, including the reserved code. A filter that checks only for Group 0 would leak the reserved-code and Secure Group 1 fields to non-secure reads. It aims partial strobes, unaligned addresses and offsets one word either side of the window at the store. A decoder off by one word would then corrupt word 8 or read data from word 24. The unimplemented top words are written secure, and lookup IDs are swept across both ends of the implemented range, so a design that still keeps values there would return nonzero data. Reads placed directly after writes, and idle cycles, show whether read data arrives late, early, or stays on the bus.

// File: rtl/xppi_prio_pkg.sv
package xppi_prio_pkg;

    localparam int PRIO_W  = 8;
    localparam int LANES   = 4;
    localparam int WORD_W  = PRIO_W * LANES;
    localparam int PRIO_SH = $clog2(PRIO_W);
    localparam int LANE_SH = $clog2(LANES);
    localparam int WORD_SH = $clog2(WORD_W);

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_mask_t;

    // Group code carried per interrupt on irq_group
    typedef enum logic [1:0] {
        GRP_G0   = 2'b00,
        GRP_SG1  = 2'b01,
        GRP_NSG1 = 2'b10,
        GRP_RSVD = 2'b11
    } irq_grp_e;

    // One access as seen by the bank after splitting read and write
    typedef struct packed {
        logic       rd;
        logic       wr;
        logic       secure;
        lane_mask_t strb;
        word_t      wdata;
    } bus_req_t;

    // A field is reachable when implemented and either the access is secure,
    // the security split is turned off, or the interrupt is non-secure group 1.
    function automatic logic field_open(irq_grp_e grp, logic implemented,
                                        logic secure, logic sec_disable);
        return implemented && (secure || sec_disable || (grp == GRP_NSG1));
    endfunction

    // Zero every lane whose keep bit is clear
    function automatic word_t mask_lanes(word_t w, lane_mask_t keep);
        word_t r;
        for (int k = 0; k < LANES; k++) begin
            r[k*PRIO_W +: PRIO_W] = keep[k] ? w[k*PRIO_W +: PRIO_W] : '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/xppi_prio_decode.sv
module xppi_prio_decode
    import xppi_prio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_OFF  = 32'h400,
    parameter int FIRST_REG = 8,
    parameter int NUM_REGS  = 16,
    parameter int RSEL_W    = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [RSEL_W-1:0] reg_sel
);

    localparam int AW_W = ADDR_W - LANE_SH;
    localparam logic [AW_W-1:0] LO_WORD = AW_W'(BASE_OFF / LANES + FIRST_REG);

    logic [AW_W-1:0] word_idx;
    logic [AW_W-1:0] rel_idx;
    logic            unused_lsb;

    assign word_idx   = addr[ADDR_W-1:LANE_SH];
    assign unused_lsb = ^addr[LANE_SH-1:0];
    assign rel_idx    = word_idx - LO_WORD;
    assign hit        = (word_idx >= LO_WORD) && (rel_idx < AW_W'(NUM_REGS));
    assign reg_sel    = rel_idx[RSEL_W-1:0];

endmodule

// File: rtl/xppi_prio_filter.sv
module xppi_prio_filter
    import xppi_prio_pkg::*;
#(
    parameter int NUM_FIELDS = 64,
    parameter int NUM_IMPL   = 56
) (
    input  logic [2*NUM_FIELDS-1:0] irq_group,
    input  logic                    secure,
    input  logic                    sec_disable,
    output logic [NUM_FIELDS-1:0]   open_mask
);

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam bit IMPL = (f < NUM_IMPL);
        assign open_mask[f] = field_open(irq_grp_e'(irq_group[2*f +: 2]),
                                         IMPL, secure, sec_disable);
    end

endmodule

// File: rtl/xppi_prio_store.sv
module xppi_prio_store
    import xppi_prio_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int NUM_IMPL = 56,
    parameter int RSEL_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [RSEL_W-1:0]          wr_sel,
    input  lane_mask_t                 wr_lanes,
    input  word_t                      wr_data,
    output logic [NUM_REGS*WORD_W-1:0] fields
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            localparam int F = r * LANES + k;
            if (F < NUM_IMPL) begin : g_impl
                prio_t q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                    end else if (wr_en && (wr_sel == RSEL_W'(r)) && wr_lanes[k]) begin
                        q <= wr_data[k*PRIO_W +: PRIO_W];
                    end
                end
                assign fields[F*PRIO_W +: PRIO_W] = q;
            end else begin : g_absent
                // No flops for interrupts that do not exist
                assign fields[F*PRIO_W +: PRIO_W] = '0;
            end
        end
    end

endmodule

// File: rtl/xppi_prio_lookup.sv
module xppi_prio_lookup
    import xppi_prio_pkg::*;
#(
    parameter int NUM_FIELDS = 64,
    parameter int NUM_IMPL   = 56,
    parameter int ID_W       = 11,
    parameter int FIRST_ID   = 1056
) (
    input  logic [ID_W-1:0]              id,
    input  logic [NUM_FIELDS*PRIO_W-1:0] fields,
    output prio_t                        prio
);

    localparam int FIDX_W = $clog2(NUM_FIELDS);

    logic [ID_W-1:0] rel_id;
    logic            in_range;

    assign rel_id   = id - ID_W'(FIRST_ID);
    assign in_range = (id >= ID_W'(FIRST_ID)) && (rel_id < ID_W'(NUM_IMPL));
    assign prio     = in_range ? fields[{rel_id[FIDX_W-1:0], {PRIO_SH{1'b0}}} +: PRIO_W]
                               : '0;

endmodule

// File: rtl/xppi_prio_bank.sv
module xppi_prio_bank
    import xppi_prio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_OFF  = 32'h400,
    parameter int FIRST_REG = 8,
    parameter int NUM_REGS  = 16,
    parameter int NUM_IMPL  = 56,
    parameter int BASE_ID   = 1024,
    parameter int ID_W      = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sec_disable,
    input  logic [8*NUM_REGS-1:0]   irq_group,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_secure,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [3:0]              req_strb,
    input  logic [31:0]             req_wdata,
    output logic [31:0]             rsp_rdata,
    input  logic [ID_W-1:0]         lookup_id,
    output logic [7:0]              lookup_prio
);

    localparam int NUM_FIELDS = NUM_REGS * LANES;
    localparam int RSEL_W     = $clog2(NUM_REGS);
    localparam int FIRST_ID   = BASE_ID + LANES * FIRST_REG;

    bus_req_t                   req;
    logic                       hit;
    logic [RSEL_W-1:0]          reg_sel;
    logic [NUM_FIELDS-1:0]      open_mask;
    lane_mask_t                 lane_open;
    lane_mask_t                 wr_lanes;
    logic [NUM_FIELDS*PRIO_W-1:0] fields;
    word_t                      sel_word;
    word_t                      rd_next;

    assign req = '{rd:     req_valid && !req_write,
                   wr:     req_valid && req_write,
                   secure: req_secure,
                   strb:   req_strb,
                   wdata:  req_wdata};

    xppi_prio_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_OFF (BASE_OFF),
        .FIRST_REG(FIRST_REG),
        .NUM_REGS (NUM_REGS),
        .RSEL_W   (RSEL_W)
    ) u_decode (
        .addr   (req_addr),
        .hit    (hit),
        .reg_sel(reg_sel)
    );

    xppi_prio_filter #(
        .NUM_FIELDS(NUM_FIELDS),
        .NUM_IMPL  (NUM_IMPL)
    ) u_filter (
        .irq_group  (irq_group),
        .secure     (req.secure),
        .sec_disable(sec_disable),
        .open_mask  (open_mask)
    );

    // Per-lane permission of the addressed word
    assign lane_open = open_mask[{reg_sel, {LANE_SH{1'b0}}} +: LANES];
    assign wr_lanes  = req.strb & lane_open;

    xppi_prio_store #(
        .NUM_REGS(NUM_REGS),
        .NUM_IMPL(NUM_IMPL),
        .RSEL_W  (RSEL_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.wr && hit),
        .wr_sel  (reg_sel),
        .wr_lanes(wr_lanes),
        .wr_data (req.wdata),
        .fields  (fields)
    );

    // Read path: select word, blank filtered lanes, register
    assign sel_word = fields[{reg_sel, {WORD_SH{1'b0}}} +: WORD_W];
    assign rd_next  = (req.rd && hit) ? mask_lanes(sel_word, lane_open) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
        end else begin
            rsp_rdata <= rd_next;
        end
    end

    xppi_prio_lookup #(
        .NUM_FIELDS(NUM_FIELDS),
        .NUM_IMPL  (NUM_IMPL),
        .ID_W      (ID_W),
        .FIRST_ID  (FIRST_ID)
    ) u_lookup (
        .id    (lookup_id),
        .fields(fields),
        .prio  (lookup_prio)
    );

endmodule

// File: rtl/xppi_prio_bank_chk.sv
module xppi_prio_bank_chk
    import xppi_prio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BASE_OFF  = 32'h400,
    parameter int FIRST_REG = 8,
    parameter int NUM_REGS  = 16,
    parameter int NUM_IMPL  = 56,
    parameter int BASE_ID   = 1024,
    parameter int ID_W      = 11
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sec_disable,
    input logic [8*NUM_REGS-1:0] irq_group,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  req_secure,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [3:0]            req_strb,
    input logic [31:0]           req_wdata,
    input logic [31:0]           rsp_rdata,
    input logic [ID_W-1:0]       lookup_id,
    input logic [7:0]            lookup_prio
);

    localparam int AW_W     = ADDR_W - 2;
    localparam int FIRST_ID = BASE_ID + 4 * FIRST_REG;
    localparam int LO_WORD  = BASE_OFF / 4 + FIRST_REG;

    logic [AW_W-1:0] word_idx;
    logic            in_window;
    int              lk_idx;
    int              lk_safe;
    logic            lk_impl;
    logic [AW_W-1:0] lk_word;
    logic [1:0]      lk_lane;
    logic [1:0]      lk_grp;
    logic [7:0]      lk_wbyte;
    logic            hit_lk;

    always_comb begin
        word_idx  = req_addr[ADDR_W-1:2];
        in_window = (int'(word_idx) >= LO_WORD) && (int'(word_idx) < LO_WORD + NUM_REGS);
        lk_idx    = int'(lookup_id) - FIRST_ID;
        lk_impl   = (lk_idx >= 0) && (lk_idx < NUM_IMPL);
        lk_safe   = lk_impl ? lk_idx : 0;
        lk_word   = AW_W'(LO_WORD + lk_safe / 4);
        lk_lane   = 2'(lk_safe % 4);
        lk_grp    = irq_group[2*lk_safe +: 2];
        lk_wbyte  = req_wdata[8*lk_lane +: 8];
        hit_lk    = req_valid && req_write && lk_impl && (word_idx == lk_word);
    end

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> (rsp_rdata == 32'h0)); // R8

    AST_UNIMPL_LOOKUP_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_impl |-> (lookup_prio == 8'h0)); // R7

    AST_OUTSIDE_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !in_window)
        |=> ($stable(lookup_id) -> $stable(lookup_prio))); // R2

    AST_NS_FILTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hit_lk && !req_secure && !sec_disable && (lk_grp != 2'b10))
        |=> ($stable(lookup_id) -> $stable(lookup_prio))); // R5

    AST_STRB_CLEAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hit_lk && !req_strb[lk_lane])
        |=> ($stable(lookup_id) -> $stable(lookup_prio))); // R4

    AST_SECURE_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (hit_lk && req_secure && req_strb[lk_lane])
        |=> ($stable(lookup_id) -> (lookup_prio == $past(lk_wbyte)))); // R6

endmodule

bind xppi_prio_bank xppi_prio_bank_chk #(
    .ADDR_W   (ADDR_W),
    .BASE_OFF (BASE_OFF),
    .FIRST_REG(FIRST_REG),
    .NUM_REGS (NUM_REGS),
    .NUM_IMPL (NUM_IMPL),
    .BASE_ID  (BASE_ID),
    .ID_W     (ID_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_disable(sec_disable),
    .irq_group  (irq_group),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .req_strb   (req_strb),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .lookup_id  (lookup_id),
    .lookup_prio(lookup_prio)
);

// File: tb/xppi_prio_bank_test.sv
module xppi_prio_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 16;
    localparam int NIMPL      = 56;
    localparam int FID        = 1056;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_disable = 1'b0;
    logic [8*NREG-1:0] irq_group = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_strb = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [10:0] lookup_id = '0;
    logic [7:0]  lookup_prio;

    int checks = 0;
    int errors = 0;
    int prio_m [NREG*4];

    always #(CLK_PERIOD/2) clk = ~clk;

    xppi_prio_bank uut (
        .clk(clk), .rst(rst), .sec_disable(sec_disable), .irq_group(irq_group),
        .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
        .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .lookup_id(lookup_id), .lookup_prio(lookup_prio)
    );

    function automatic bit may(int idx, bit s);
        if (idx < 0 || idx >= NIMPL) return 1'b0;
        return s || sec_disable || (irq_group[2*idx +: 2] == 2'b10);
    endfunction

    function automatic logic [31:0] model_read(int addr, bit s);
        logic [31:0] r = '0;
        int n = (addr >> 2) - 256;
        if (n < 8 || n > 23) return '0;
        for (int k = 0; k < 4; k++) begin
            int idx = (n - 8) * 4 + k;
            if (may(idx, s)) r[k*8 +: 8] = 8'(prio_m[idx]);
        end
        return r;
    endfunction

    task automatic model_write(int addr, bit s, logic [31:0] d, logic [3:0] st);
        int n = (addr >> 2) - 256;
        if (n < 8 || n > 23) return;
        for (int k = 0; k < 4; k++) begin
            int idx = (n - 8) * 4 + k;
            if (st[k] && may(idx, s)) prio_m[idx] = int'(d[k*8 +: 8]);
        end
    endtask

    function automatic logic [7:0] model_lookup(int id);
        if (id >= FID && id < FID + NIMPL) return 8'(prio_m[id - FID]);
        return 8'h0;
    endfunction

    function automatic logic [31:0] pat(int n, int salt);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[k*8 +: 8] = 8'(salt + 4 * n + k);
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive, advance model, compare both outputs after the edge
    task automatic step(bit v, bit w, bit s, int addr, logic [31:0] d,
                        logic [3:0] st, int lkid, string tag);
        logic [31:0] exp_rd;
        req_valid  = v;
        req_write  = w;
        req_secure = s;
        req_addr   = 16'(addr);
        req_wdata  = d;
        req_strb   = st;
        lookup_id  = 11'(lkid);
        exp_rd = (v && !w) ? model_read(addr, s) : 32'h0;
        if (v && w) model_write(addr, s, d, st);
        @(posedge clk);
        #1;
        chk(tag, rsp_rdata, exp_rd);
        chk(tag, {24'h0, lookup_prio}, {24'h0, model_lookup(lkid)});
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG*4; i++) begin
            prio_m[i] = 0;
            irq_group[2*i +: 2] = 2'(i % 4);
        end
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset contents
        chk("R1", rsp_rdata, 32'h0);
        step(1, 0, 1, 'h420, 0, 0, FID, "R1");
        step(1, 0, 1, 'h43C, 0, 0, FID + 30, "R1");
        step(1, 0, 1, 'h45C, 0, 0, FID + 55, "R1");

        // R6: secure writes fill every word
        for (int n = 8; n < 24; n++)
            step(1, 1, 1, 'h400 + 4*n, pat(n, 'h10), 4'hF, FID + 4*(n-8) + (n % 4), "R6");

        // R3: secure read back, lane order
        for (int n = 8; n < 24; n++)
            step(1, 0, 1, 'h400 + 4*n, 0, 0, FID + 4*(n-8) + 3, "R3");

        // R5: non-secure view with split enabled
        for (int n = 8; n < 24; n++)
            step(1, 0, 0, 'h400 + 4*n, 0, 0, FID + 4*(n-8) + 1, "R5");
        for (int n = 8; n < 24; n++)
            step(1, 1, 0, 'h400 + 4*n, pat(n, 'h80), 4'hF, FID + 4*(n-8) + (n % 2) * 2, "R5");
        for (int n = 8; n < 24; n++)
            step(1, 0, 1, 'h400 + 4*n, 0, 0, FID + 4*(n-8), "R5");

        // R4: partial strobes
        step(1, 1, 1, 'h424, 32'hC1C2C3C4, 4'b0101, FID + 4, "R4");
        step(1, 1, 1, 'h428, 32'hD1D2D3D4, 4'b0000, FID + 9, "R4");
        step(1, 1, 1, 'h42C, 32'hE1E2E3E4, 4'b1000, FID + 15, "R4");
        step(1, 0, 1, 'h424, 0, 0, FID + 5, "R4");
        step(1, 0, 1, 'h428, 0, 0, FID + 8, "R4");
        step(1, 0, 1, 'h42C, 0, 0, FID + 14, "R4");

        // R2: offsets outside the window and unaligned addresses
        step(1, 1, 1, 'h41C, 32'h11111111, 4'hF, FID, "R2");
        step(1, 1, 1, 'h460, 32'h22222222, 4'hF, FID + 55, "R2");
        step(1, 1, 1, 'h000, 32'h33333333, 4'hF, FID + 1, "R2");
        step(1, 1, 1, 'hFFFC, 32'h44444444, 4'hF, FID + 2, "R2");
        step(1, 0, 1, 'h41C, 0, 0, FID, "R2");
        step(1, 0, 1, 'h460, 0, 0, FID, "R2");
        step(1, 1, 1, 'h423, 32'h0000005A, 4'b0001, FID, "R2");
        step(1, 0, 1, 'h421, 0, 0, FID, "R2");

        // R7: unimplemented words and IDs
        step(1, 1, 1, 'h458, 32'hA5A5A5A5, 4'hF, FID + 56, "R7");
        step(1, 1, 1, 'h45C, 32'h5A5A5A5A, 4'hF, FID + 63, "R7");
        step(1, 0, 1, 'h458, 0, 0, FID + 55, "R7");
        step(1, 0, 1, 'h45C, 0, 0, FID - 1, "R7");
        step(0, 0, 0, 0, 0, 0, FID + 64, "R7");
        step(0, 0, 0, 0, 0, 0, 0, "R7");

        // R6: security split disabled opens every implemented field
        sec_disable = 1'b1;
        for (int n = 8; n < 24; n++)
            step(1, 1, 0, 'h400 + 4*n, pat(n, 'hE0), 4'hF, FID + 4*(n-8), "R6");
        for (int n = 8; n < 24; n++)
            step(1, 0, 0, 'h400 + 4*n, 0, 0, FID + 4*(n-8) + 1, "R6");
        sec_disable = 1'b0;

        // R8: idle cycles and write-then-read timing
        step(0, 0, 0, 'h420, 0, 0, FID, "R8");
        step(1, 1, 1, 'h430, 32'h0F0E0D0C, 4'hF, FID + 16, "R8");
        step(1, 0, 1, 'h430, 0, 0, FID + 17, "R8");
        step(0, 0, 0, 'h430, 0, 0, FID + 18, "R8");
        step(0, 0, 0, 'h430, 0, 0, FID + 19, "R8");

        // R9: lookup sweep across and beyond the range
        for (int id = FID - 6; id < FID + 70; id++)
            step(0, 0, 0, 0, 0, 0, id, "R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule